// File: doc/BRIEF.md
# Half-Rate Memory Read Front End

This block sits between user logic that wants to read memory and the physical-layer side of a half-rate memory datapath. User logic presents a local word address and a burst size. The block parks each accepted request in a short command queue, splits the address into bank, row and column fields, and sends the requests to the physical side one read command at a time, in the order they were taken.

Each command comes with an expected-data strobe that stays high for as many cycles as the burst will return. The physical side uses it to open its capture window. Returned read data and its valid flag go back to the user in arrival order. A chosen fixed number of pipeline stages can be inserted on that path, standing in for an error-correction stage.

The queue applies back-pressure. Ready drops while the queue is full, so the user may hold a request until the block takes it.

Top module: `hrrd_frontend`

## Requirements
- R1: A request is accepted only on a rising clock edge where `rd_req` and `rd_ready` are both high. `rd_ready` is low exactly while the queue holds `DEPTH` entries (default 4), and a request held high while `rd_ready` is low is not taken.
- R2: The column of a command equals the local address bits `[COL_W-3:0]` shifted left by two, so column bits `[1:0]` are always zero. Local address 2 gives column 8.
- R3: The row is the next `ROW_W` local address bits above the column part, and the bank is the top `BANK_W` bits. With defaults, row = addr[20:8] and bank = addr[23:21]. Local address 0 gives bank 0, row 0, column 0.
- R4: Every accepted request produces exactly one `mem_cmd_valid` cycle carrying its fields. Commands leave in acceptance order, including back-to-back requests to different columns of one row.
- R5: On an idle, empty front end, a request accepted at clock edge n shows `mem_cmd_valid` high during the cycle that follows edge n+1.
- R6: `mem_exp_rd` is high for exactly `mem_len` consecutive cycles, starting in the cycle of `mem_cmd_valid`. `mem_len` equals the request size, except that a size of 0 is issued as 1.
- R7: No command is issued while the previous strobe is still running. With more requests waiting, the next command comes in the cycle right after the last strobe cycle, so commands are spaced exactly by the previous length.
- R8: With `RD_LAT` = 0, `usr_rvalid` and `usr_rdata` follow `phy_rvalid` and `phy_rdata` in the same cycle.
- R9: With `RD_LAT` = 1 or 3, `usr_rvalid` and `usr_rdata` repeat `phy_rvalid` and `phy_rdata` exactly `RD_LAT` cycles later, keeping order.
- R10: A synchronous active-high `rst` empties the queue, stops any running strobe and clears `mem_cmd_valid` and the delayed `usr_rvalid`. `rd_ready` is high after reset, and no queued request is issued after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | User read request |
| rd_addr | input | LADDR_W | Local word address (default 24 bits) |
| rd_size | input | SIZE_W | Burst length in cycles |
| rd_ready | output | 1 | Queue has room |
| mem_cmd_valid | output | 1 | One-cycle read command toward the physical side |
| mem_row | output | ROW_W | Row of the command |
| mem_col | output | COL_W | Column of the command |
| mem_bank | output | BANK_W | Bank of the command |
| mem_len | output | SIZE_W | Effective burst length of the command |
| mem_exp_rd | output | 1 | Expected-read-data strobe |
| phy_rvalid | input | 1 | Read data valid from the physical side |
| phy_rdata | input | DATA_W | Read data from the physical side |
| usr_rvalid | output | 1 | Read data valid toward the user |
| usr_rdata | output | DATA_W | Read data toward the user |

## Verification
The bound checker watches these on every cycle:
- the strobe length against `mem_len`;
- that no command starts while a strobe is still running;
- that column bits [1:0] are zero;
- the return path matching its input delayed by `RD_LAT`;
- the state right after reset.

Only the directed scenarios can show the rest:
- the full address split, including high row and bank bits;
- command order and the one-to-one link between accepted requests and commands;
- the exact issue latency from acceptance;
- that a request held against a full queue is neither lost nor duplicated;
- that a reset in the middle of work drops the queued entries.

// File: rtl/hrrd_pkg.sv
package hrrd_pkg;

    // Half-rate column scaling: local column part is shifted by this amount.
    localparam int unsigned HALF_RATE_SH = 2;

    // Default geometry of the datapath.
    localparam int unsigned DEF_COL_W  = 10;
    localparam int unsigned DEF_ROW_W  = 13;
    localparam int unsigned DEF_BANK_W = 3;
    localparam int unsigned DEF_SIZE_W = 3;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_DEPTH  = 4;

    // Width of the local word address for a given geometry.
    function automatic int unsigned laddr_width(int unsigned col_w,
                                                int unsigned row_w,
                                                int unsigned bank_w);
        return col_w - HALF_RATE_SH + row_w + bank_w;
    endfunction

endpackage

// File: rtl/hrrd_cmd_fifo.sv
module hrrd_cmd_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

endmodule

// File: rtl/hrrd_addr_map.sv
module hrrd_addr_map
    import hrrd_pkg::*;
#(
    parameter int unsigned COL_W  = DEF_COL_W,
    parameter int unsigned ROW_W  = DEF_ROW_W,
    parameter int unsigned BANK_W = DEF_BANK_W,
    localparam int unsigned CPART_W = COL_W - HALF_RATE_SH,
    localparam int unsigned LADDR_W = CPART_W + ROW_W + BANK_W
) (
    input  logic [LADDR_W-1:0] laddr,
    output logic [COL_W-1:0]   col,
    output logic [ROW_W-1:0]   row,
    output logic [BANK_W-1:0]  bank
);

    // Column first, then row, then bank, from the low end of the address.
    assign col  = {laddr[CPART_W-1:0], {HALF_RATE_SH{1'b0}}};
    assign row  = laddr[CPART_W +: ROW_W];
    assign bank = laddr[CPART_W + ROW_W +: BANK_W];

endmodule

// File: rtl/hrrd_issue.sv
module hrrd_issue #(
    parameter int unsigned ADR_W  = 26,
    parameter int unsigned SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              empty,
    input  logic [ADR_W-1:0]  head_adr,
    input  logic [SIZE_W-1:0] head_len,
    output logic              pop,
    output logic              cmd_valid,
    output logic [ADR_W-1:0]  cmd_adr,
    output logic [SIZE_W-1:0] cmd_len,
    output logic              exp_rd
);

    // Strobe cycles still to run, counting the current one.
    logic [SIZE_W-1:0] rem_q;
    logic [SIZE_W-1:0] eff_len;
    logic              slot_free;

    assign eff_len   = (head_len == '0) ? SIZE_W'(1) : head_len;
    assign slot_free = (rem_q <= SIZE_W'(1));
    assign pop       = !empty && slot_free;
    assign exp_rd    = (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= '0;
            cmd_valid <= 1'b0;
            cmd_adr   <= '0;
            cmd_len   <= '0;
        end else begin
            cmd_valid <= pop;
            if (pop) begin
                cmd_adr <= head_adr;
                cmd_len <= eff_len;
                rem_q   <= eff_len;
            end else if (rem_q != '0) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/hrrd_rdata_pipe.sv
module hrrd_rdata_pipe #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RD_LAT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    generate
        if (RD_LAT == 0) begin : g_bypass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_stages
            logic              v_sr [RD_LAT];
            logic [DATA_W-1:0] d_sr [RD_LAT];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(RD_LAT); i++) begin
                        v_sr[i] <= 1'b0;
                    end
                end else begin
                    v_sr[0] <= in_valid;
                    for (int i = 1; i < int'(RD_LAT); i++) begin
                        v_sr[i] <= v_sr[i-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                d_sr[0] <= in_data;
                for (int i = 1; i < int'(RD_LAT); i++) begin
                    d_sr[i] <= d_sr[i-1];
                end
            end

            assign out_valid = v_sr[RD_LAT-1];
            assign out_data  = d_sr[RD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/hrrd_frontend.sv
module hrrd_frontend
    import hrrd_pkg::*;
#(
    parameter int unsigned COL_W  = DEF_COL_W,
    parameter int unsigned ROW_W  = DEF_ROW_W,
    parameter int unsigned BANK_W = DEF_BANK_W,
    parameter int unsigned SIZE_W = DEF_SIZE_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned RD_LAT = 0,
    localparam int unsigned LADDR_W = laddr_width(COL_W, ROW_W, BANK_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_req,
    input  logic [LADDR_W-1:0] rd_addr,
    input  logic [SIZE_W-1:0]  rd_size,
    output logic               rd_ready,
    output logic               mem_cmd_valid,
    output logic [ROW_W-1:0]   mem_row,
    output logic [COL_W-1:0]   mem_col,
    output logic [BANK_W-1:0]  mem_bank,
    output logic [SIZE_W-1:0]  mem_len,
    output logic               mem_exp_rd,
    input  logic               phy_rvalid,
    input  logic [DATA_W-1:0]  phy_rdata,
    output logic               usr_rvalid,
    output logic [DATA_W-1:0]  usr_rdata
);

    localparam int unsigned ADR_W = BANK_W + ROW_W + COL_W;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } mem_adr_t;

    typedef struct packed {
        mem_adr_t          adr;
        logic [SIZE_W-1:0] len;
    } rd_cmd_t;

    localparam int unsigned CMD_W = $bits(rd_cmd_t);

    rd_cmd_t  new_cmd;
    rd_cmd_t  head_cmd;
    mem_adr_t issued_adr;
    logic     q_full;
    logic     q_empty;
    logic     q_pop;
    logic     accept;

    assign rd_ready = !q_full;
    assign accept   = rd_req && rd_ready;

    hrrd_addr_map #(
        .COL_W  (COL_W),
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_map (
        .laddr (rd_addr),
        .col   (new_cmd.adr.col),
        .row   (new_cmd.adr.row),
        .bank  (new_cmd.adr.bank)
    );

    assign new_cmd.len = rd_size;

    hrrd_cmd_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (accept),
        .din   (new_cmd),
        .pop   (q_pop),
        .dout  (head_cmd),
        .full  (q_full),
        .empty (q_empty)
    );

    hrrd_issue #(
        .ADR_W  (ADR_W),
        .SIZE_W (SIZE_W)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .empty     (q_empty),
        .head_adr  (head_cmd.adr),
        .head_len  (head_cmd.len),
        .pop       (q_pop),
        .cmd_valid (mem_cmd_valid),
        .cmd_adr   (issued_adr),
        .cmd_len   (mem_len),
        .exp_rd    (mem_exp_rd)
    );

    assign mem_row  = issued_adr.row;
    assign mem_col  = issued_adr.col;
    assign mem_bank = issued_adr.bank;

    hrrd_rdata_pipe #(
        .DATA_W (DATA_W),
        .RD_LAT (RD_LAT)
    ) u_ret (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (phy_rvalid),
        .in_data   (phy_rdata),
        .out_valid (usr_rvalid),
        .out_data  (usr_rdata)
    );

endmodule

// File: rtl/hrrd_frontend_chk.sv
module hrrd_frontend_chk #(
    parameter int unsigned COL_W  = 10,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RD_LAT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_ready,
    input logic              mem_cmd_valid,
    input logic [COL_W-1:0]  mem_col,
    input logic [SIZE_W-1:0] mem_len,
    input logic              mem_exp_rd,
    input logic              phy_rvalid,
    input logic [DATA_W-1:0] phy_rdata,
    input logic              usr_rvalid,
    input logic [DATA_W-1:0] usr_rdata
);

    // Strobe cycles still owed after the current cycle, tracked from the ports.
    logic [SIZE_W-1:0] owed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= '0;
        end else if (mem_cmd_valid) begin
            owed_q <= mem_len - 1'b1;
        end else if (owed_q != '0) begin
            owed_q <= owed_q - 1'b1;
        end
    end

    // R6
    nonzero_len_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid |-> (mem_len != '0));

    // R6
    strobe_span_chk: assert property (@(posedge clk) disable iff (rst)
        mem_exp_rd == (mem_cmd_valid || (owed_q != '0)));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid |-> (owed_q == '0));

    // R2
    col_scaled_chk: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid |-> (mem_col[1:0] == 2'b00));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_ready && !mem_cmd_valid && !mem_exp_rd));

    generate
        if (RD_LAT == 0) begin : g_lat0
            // R8
            pass_valid_chk: assert property (@(posedge clk) disable iff (rst)
                usr_rvalid == phy_rvalid);
            // R8
            pass_data_chk: assert property (@(posedge clk) disable iff (rst)
                phy_rvalid |-> (usr_rdata == phy_rdata));
        end else begin : g_latn
            logic [2:0] warm_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    warm_q <= '0;
                end else if (warm_q != 3'd7) begin
                    warm_q <= warm_q + 1'b1;
                end
            end
            // R9
            delay_valid_chk: assert property (@(posedge clk) disable iff (rst)
                (warm_q >= 3'(RD_LAT)) |-> (usr_rvalid == $past(phy_rvalid, RD_LAT)));
            // R9
            delay_data_chk: assert property (@(posedge clk) disable iff (rst)
                ((warm_q >= 3'(RD_LAT)) && usr_rvalid) |-> (usr_rdata == $past(phy_rdata, RD_LAT)));
            // R10
            ret_clear_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !usr_rvalid);
        end
    endgenerate

endmodule

bind hrrd_frontend hrrd_frontend_chk #(
    .COL_W  (COL_W),
    .SIZE_W (SIZE_W),
    .DATA_W (DATA_W),
    .RD_LAT (RD_LAT)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rd_ready      (rd_ready),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_col       (mem_col),
    .mem_len       (mem_len),
    .mem_exp_rd    (mem_exp_rd),
    .phy_rvalid    (phy_rvalid),
    .phy_rdata     (phy_rdata),
    .usr_rvalid    (usr_rvalid),
    .usr_rdata     (usr_rdata)
);

// File: tb/hrrd_frontend_tb.sv
`timescale 1ns/1ps
module hrrd_frontend_tb;

    localparam int LADDR_W = 24;
    localparam int COL_W   = 10;
    localparam int ROW_W   = 13;
    localparam int BANK_W  = 3;
    localparam int SIZE_W  = 3;
    localparam int DATA_W  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_req = 1'b0;
    logic [LADDR_W-1:0] rd_addr = '0;
    logic [SIZE_W-1:0] rd_size = '0;
    logic              rd_ready;
    logic              mem_cmd_valid;
    logic [ROW_W-1:0]  mem_row;
    logic [COL_W-1:0]  mem_col;
    logic [BANK_W-1:0] mem_bank;
    logic [SIZE_W-1:0] mem_len;
    logic              mem_exp_rd;
    logic              phy_rvalid = 1'b0;
    logic [DATA_W-1:0] phy_rdata = '0;
    logic              usr_rvalid;
    logic [DATA_W-1:0] usr_rdata;

    logic              z_ready, z_cv, z_exp, z_rv;
    logic [ROW_W-1:0]  z_row;
    logic [COL_W-1:0]  z_col;
    logic [BANK_W-1:0] z_bank;
    logic [SIZE_W-1:0] z_len;
    logic [DATA_W-1:0] z_rd;

    always #2 clk = ~clk;

    hrrd_frontend #(.RD_LAT(3)) u_dut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ready(rd_ready), .mem_cmd_valid(mem_cmd_valid), .mem_row(mem_row),
        .mem_col(mem_col), .mem_bank(mem_bank), .mem_len(mem_len), .mem_exp_rd(mem_exp_rd),
        .phy_rvalid(phy_rvalid), .phy_rdata(phy_rdata),
        .usr_rvalid(usr_rvalid), .usr_rdata(usr_rdata)
    );

    hrrd_frontend #(.RD_LAT(0)) u_dut_l0 (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ready(z_ready), .mem_cmd_valid(z_cv), .mem_row(z_row),
        .mem_col(z_col), .mem_bank(z_bank), .mem_len(z_len), .mem_exp_rd(z_exp),
        .phy_rvalid(phy_rvalid), .phy_rdata(phy_rdata),
        .usr_rvalid(z_rv), .usr_rdata(z_rd)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Command monitor
    int ncmd = 0;
    int orphan = 0;
    int log_row [64];
    int log_col [64];
    int log_bank[64];
    int log_len [64];
    int log_cyc [64];
    int strb    [64];

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_cmd_valid && ncmd < 64) begin
                log_row[ncmd]  = int'(mem_row);
                log_col[ncmd]  = int'(mem_col);
                log_bank[ncmd] = int'(mem_bank);
                log_len[ncmd]  = int'(mem_len);
                log_cyc[ncmd]  = cyc;
                strb[ncmd]     = 0;
                ncmd++;
            end
            if (mem_exp_rd) begin
                if (ncmd == 0) orphan++;
                else strb[ncmd-1]++;
            end
        end
    end

    // Request stimulus
    int req_a [64];
    int req_s [64];
    int acc_c [64];
    int low_cnt;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int e_col(input int a);  return (a & 'hFF) << 2;     endfunction
    function automatic int e_row(input int a);  return (a >> 8) & 'h1FFF;   endfunction
    function automatic int e_bank(input int a); return (a >> 21) & 7;       endfunction

    task automatic clear_log();
        ncmd = 0;
        orphan = 0;
    endtask

    task automatic push_n(input int n);
        int i;
        i = 0;
        low_cnt = 0;
        @(posedge clk); #1;
        rd_req  = 1'b1;
        rd_addr = LADDR_W'(req_a[0]);
        rd_size = SIZE_W'(req_s[0]);
        while (i < n) begin
            logic rdy;
            @(negedge clk);
            rdy = rd_ready;
            @(posedge clk); #1;
            if (rdy) begin
                acc_c[i] = cyc;
                i++;
                if (i < n) begin
                    rd_addr = LADDR_W'(req_a[i]);
                    rd_size = SIZE_W'(req_s[i]);
                end else begin
                    rd_req = 1'b0;
                end
            end else begin
                low_cnt++;
            end
        end
    endtask

    task automatic settle();
        repeat (80) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R10: outputs cleared while in reset
        chk(rd_ready == 1'b1, "R10 ready in reset", rd_ready, 1);
        chk(mem_cmd_valid == 1'b0, "R10 cmd_valid in reset", mem_cmd_valid, 0);
        chk(mem_exp_rd == 1'b0, "R10 exp_rd in reset", mem_exp_rd, 0);
        chk(usr_rvalid == 1'b0, "R10 usr_rvalid in reset", usr_rvalid, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        clear_log();
    endtask

    task automatic t_basic();
        clear_log();
        req_a[0] = 0; req_s[0] = 2;
        req_a[1] = 2; req_s[1] = 2;
        push_n(2);
        settle();
        chk(ncmd == 2, "R4 command count", ncmd, 2);
        chk(log_row[0] == 0 && log_col[0] == 0 && log_bank[0] == 0, "R3 addr 0 fields",
            log_col[0], 0);
        chk(log_col[1] == 8, "R2 addr 2 column", log_col[1], 8);
        chk(log_row[1] == 0 && log_bank[1] == 0, "R3 addr 2 row/bank", log_row[1], 0);
        chk(strb[0] == 2 && strb[1] == 2, "R6 strobe length 2", strb[0], 2);
        chk(log_cyc[0] == acc_c[0] + 1, "R5 issue latency", log_cyc[0], acc_c[0] + 1);
        chk(log_cyc[1] - log_cyc[0] == 2, "R7 back-to-back spacing",
            log_cyc[1] - log_cyc[0], 2);
        chk(orphan == 0, "R6 strobe without command", orphan, 0);
    endtask

    task automatic t_fields();
        clear_log();
        req_a[0] = (5 << 21) | ('h1234 << 8) | 'hAB; req_s[0] = 1;
        req_a[1] = 'hFFFFFF;                         req_s[1] = 3;
        push_n(2);
        settle();
        chk(ncmd == 2, "R4 command count fields", ncmd, 2);
        for (int k = 0; k < 2; k++) begin
            chk(log_col[k] == e_col(req_a[k]), "R2 column split", log_col[k], e_col(req_a[k]));
            chk(log_row[k] == e_row(req_a[k]), "R3 row split", log_row[k], e_row(req_a[k]));
            chk(log_bank[k] == e_bank(req_a[k]), "R3 bank split", log_bank[k], e_bank(req_a[k]));
            chk(strb[k] == req_s[k] && log_len[k] == req_s[k], "R6 strobe length",
                strb[k], req_s[k]);
        end
    endtask

    task automatic t_zero_size();
        clear_log();
        req_a[0] = 'h40; req_s[0] = 0;
        push_n(1);
        settle();
        chk(ncmd == 1, "R4 zero-size command issued", ncmd, 1);
        chk(log_len[0] == 1, "R6 zero size issued as 1", log_len[0], 1);
        chk(strb[0] == 1, "R6 zero size strobe", strb[0], 1);
    endtask

    task automatic t_fill();
        clear_log();
        for (int k = 0; k < 7; k++) begin
            req_a[k] = (k << 8) | (k * 4 + 1);
            req_s[k] = 7;
        end
        push_n(7);
        settle();
        chk(low_cnt > 0, "R1 ready dropped when queue full", low_cnt, 1);
        chk(ncmd == 7, "R1 R4 one command per accepted request", ncmd, 7);
        for (int k = 0; k < 7; k++) begin
            chk(log_col[k] == e_col(req_a[k]) && log_row[k] == e_row(req_a[k]),
                "R4 order preserved", log_col[k], e_col(req_a[k]));
            chk(strb[k] == 7, "R6 strobe length 7", strb[k], 7);
        end
        for (int k = 1; k < 7; k++) begin
            chk(log_cyc[k] - log_cyc[k-1] == 7, "R7 spacing equals length",
                log_cyc[k] - log_cyc[k-1], 7);
        end
    endtask

    task automatic t_rdata();
        bit vin [12];
        int din [12];
        bit o0v [12];
        int o0d [12];
        bit o3v [12];
        int o3d [12];
        bit pat [12] = '{1,1,0,1,0,0,1,1,1,0,1,0};
        for (int i = 0; i < 12; i++) begin
            vin[i] = pat[i];
            din[i] = 'hA5000000 + i * 'h111;
            @(posedge clk); #1;
            phy_rvalid = vin[i];
            phy_rdata  = DATA_W'(din[i]);
            @(negedge clk);
            o0v[i] = z_rv;    o0d[i] = int'(z_rd);
            o3v[i] = usr_rvalid; o3d[i] = int'(usr_rdata);
        end
        @(posedge clk); #1;
        phy_rvalid = 1'b0;
        for (int i = 0; i < 12; i++) begin
            chk(o0v[i] == vin[i] && (!vin[i] || o0d[i] == din[i]), "R8 zero-latency pass",
                o0d[i], din[i]);
            if (i >= 3)
                chk(o3v[i] == vin[i-3] && (!vin[i-3] || o3d[i] == din[i-3]),
                    "R9 three-cycle delay", o3d[i], din[i-3]);
            else
                chk(o3v[i] == 1'b0, "R9 no early data", o3v[i], 0);
        end
    endtask

    task automatic t_reset_mid();
        clear_log();
        for (int k = 0; k < 4; k++) begin
            req_a[k] = 'h100 + k; req_s[k] = 7;
        end
        push_n(4);
        do_reset();
        settle();
        chk(ncmd == 0, "R10 queue emptied by reset", ncmd, 0);
        chk(orphan == 0, "R10 strobe stopped by reset", orphan, 0);
        chk(rd_ready == 1'b1, "R10 ready after reset", rd_ready, 1);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_ready == 1'b1, "R10 ready at reset", rd_ready, 1);
        chk(mem_cmd_valid == 1'b0 && mem_exp_rd == 1'b0, "R10 idle at reset", mem_exp_rd, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        clear_log();
        t_basic();
        t_fields();
        t_zero_size();
        t_fill();
        t_rdata();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule